// File: doc/BRIEF.md
# Interlaced Master Video Sync Generator

This block is the timing master of a standard-definition video path. It runs on a 27 MHz clock and produces its own 13.5 MHz pixel-rate enable. From that enable it counts pixel positions along each line and counts the lines of an interlaced frame. It drives active-low horizontal and vertical sync for the upstream decoder. It also publishes the pixel position, the line number and the field flag, so that neighbouring blocks can align their data to the same raster.

A two-bit mode input selects the raster geometry. Code `11` selects 525-line timing with 858 pixels per line, and `01` selects the same 525-line geometry (the 60 Hz PAL variant). Code `10` selects 625-line timing with 864 pixels per line. Code `00` parks the raster.

The mode is sampled once per frame, at the frame wrap. A frame that has started therefore always completes with the geometry it began with. Field tracking is done by a small state machine with three states: `FS_SLEEP`, `FS_ODD` and `FS_EVEN`. It has four transitions:

- wake, `FS_SLEEP`→`FS_ODD`, on a pixel enable while the mode is not `00`;
- field flip, `FS_ODD`→`FS_EVEN`, at the end of the line before the second field;
- frame wrap, `FS_EVEN`→`FS_ODD`, when the last pixel of the last line passes and the mode is not `00`;
- park, `FS_EVEN`→`FS_SLEEP`, at the same point when the mode is `00`.

Top module: `ilace_sync_gen`

## Requirements
- R1: The pixel counter `h_pos` counts from 0 to H−1, where H is `H_NTSC` for modes `11` and `01` and `H_PAL` for mode `10`. One line therefore lasts 2·H clocks.
- R2: `line_num` counts from 1 to V, where V is `V_NTSC` for modes `11` and `01` and `V_PAL` for mode `10`. After line V it returns to 1.
- R3: `hsync_n` goes low on the clock after `h_pos` is 0. It stays low for exactly 2·`HS_PIX` clocks (64 by default) on every line.
- R4: `vsync_n` stays low for exactly `VS_LINES` lines (4·H clocks by default) once per field.
- R5: In the odd field, `vsync_n` falls in the same clock as `hsync_n` on line VO. In the even field, it falls H clocks after `hsync_n` on line F2+VO−1, which is half a line later. VO is `VS_ODD_NTSC` or `VS_ODD_PAL`, and F2 = (V+1)/2.
- R6: `field_even` is 0 on lines 1 to F2−1 and 1 on lines F2 to V. It rises together with the entry into line F2.
- R7: `pix_en` alternates on every clock, in every mode, sleep included. `h_pos` moves only on clocks where `pix_en` is 1.
- R8: With mode `00`, the raster parks at the next frame wrap. It holds at line 1, pixel 0, with `field_even` 0, and `hsync_n` and `vsync_n` are held high. A non-`00` mode seen on a `pix_en` clock restarts the odd field at line 1, and `hsync_n` falls within three clocks.
- R9: A change on `mode` in the middle of a frame has no effect until that frame wraps.
- R10: Synchronous reset sets `line_num` to 1, `h_pos` to 0 and `field_even` to 0. It also sets `pix_en` to 0, sets both syncs high, and adopts the mode present on `mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz double-pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 11 525-line, 10 625-line, 01 525-line 60 Hz PAL, 00 sleep |
| pix_en | output | 1 | Pixel-rate enable, high every second clock |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| h_pos | output | HW | Current pixel position in the line |
| line_num | output | LW | Current line number, counted from 1 |
| field_even | output | 1 | 1 while the second field is being scanned |

## Verification
In the odd field, the vertical window opens on the same pixel-0 boundary that starts a horizontal pulse. Both registered syncs therefore fall in one clock. The bench measures the distance between the two falling edges in both fields and expects 0 clocks in the odd field and H clocks in the even field. The second collision is between a frame wrap and a change on `mode`. The bench drives a new code partway through a frame, then confirms that the longest line and the highest line number of that frame still belong to the old geometry. It then confirms that the following frame uses the new geometry.

// File: rtl/isg_pkg.sv
package isg_pkg;
    // Mode pin encoding; the raster geometry decodes these values.
    typedef enum logic [1:0] {
        MODE_SLEEP = 2'b00,
        MODE_PAL60 = 2'b01,
        MODE_PAL   = 2'b10,
        MODE_NTSC  = 2'b11
    } vmode_e;

    // Field tracking states.
    typedef enum logic [1:0] {
        FS_SLEEP = 2'b00,
        FS_ODD   = 2'b01,
        FS_EVEN  = 2'b10
    } fstate_e;
endpackage

// File: rtl/isg_phase.sv
module isg_phase (
    input  logic clk,
    input  logic rst,
    output logic pix_en
);
    // Divides the double-pixel clock into a one-in-two enable; never stops.
    always_ff @(posedge clk) begin
        if (rst) pix_en <= 1'b0;
        else     pix_en <= ~pix_en;
    end
endmodule

// File: rtl/isg_counters.sv
module isg_counters #(
    parameter int HW = 10,
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [HW-1:0] h_max,
    input  logic [LW-1:0] v_max,
    output logic [HW-1:0] h_pos,
    output logic [LW-1:0] line_num,
    output logic          line_end,
    output logic          frame_end
);
    always_comb begin
        line_end  = (h_pos == h_max - HW'(1));
        frame_end = line_end && (line_num == v_max);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_pos    <= '0;
            line_num <= LW'(1);
        end else if (adv) begin
            if (line_end) begin
                h_pos    <= '0;
                line_num <= frame_end ? LW'(1) : line_num + LW'(1);
            end else begin
                h_pos <= h_pos + HW'(1);
            end
        end
    end

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(h_pos));

    // R1
    hpos_range_chk: assert property (@(posedge clk) disable iff (rst)
        h_pos < h_max);
endmodule

// File: rtl/isg_field_fsm.sv
module isg_field_fsm #(
    parameter int LW = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  isg_pkg::vmode_e mode_in,
    input  logic            tick,
    input  logic            line_end,
    input  logic            frame_end,
    input  logic [LW-1:0]   line_num,
    input  logic [LW-1:0]   f2_line,
    output isg_pkg::vmode_e cur_mode,
    output logic            run,
    output logic            field_even
);
    import isg_pkg::*;

    fstate_e state, nxt;
    logic    load;

    // Next-state logic.
    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            FS_SLEEP: begin
                if (tick && mode_in != MODE_SLEEP) begin
                    nxt  = FS_ODD;
                    load = 1'b1;
                end
            end
            FS_ODD: begin
                if (tick && line_end && line_num == f2_line - LW'(1))
                    nxt = FS_EVEN;
            end
            FS_EVEN: begin
                if (tick && frame_end) begin
                    load = 1'b1;
                    nxt  = (mode_in == MODE_SLEEP) ? FS_SLEEP : FS_ODD;
                end
            end
            default: nxt = FS_ODD;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= (mode_in == MODE_SLEEP) ? FS_SLEEP : FS_ODD;
            cur_mode <= mode_in;
        end else begin
            state <= nxt;
            if (load) cur_mode <= mode_in;
        end
    end

    // Outputs.
    always_comb begin
        run        = (state != FS_SLEEP);
        field_even = (state == FS_EVEN);
    end

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != FS_SLEEP && !(tick && frame_end)) |=> $stable(cur_mode));

    // R6
    even_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(field_even) |-> (line_num == f2_line));
endmodule

// File: rtl/isg_sync_decode.sv
module isg_sync_decode #(
    parameter int HW       = 10,
    parameter int LW       = 10,
    parameter int HS_PIX   = 32,
    parameter int VS_LINES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          field_even,
    input  logic [HW-1:0] h_pos,
    input  logic [LW-1:0] line_num,
    input  logic [HW-1:0] h_half,
    input  logic [LW-1:0] vs_odd_line,
    input  logic [LW-1:0] vs_even_line,
    output logic          hsync_n,
    output logic          vsync_n
);
    logic hs_act, vs_act, vs_odd_win, vs_even_win;

    always_comb begin
        vs_odd_win  = (line_num >= vs_odd_line) &&
                      (line_num <  vs_odd_line + LW'(VS_LINES));
        vs_even_win = ((line_num == vs_even_line) && (h_pos >= h_half)) ||
                      ((line_num >  vs_even_line) &&
                       (line_num <  vs_even_line + LW'(VS_LINES))) ||
                      ((line_num == vs_even_line + LW'(VS_LINES)) && (h_pos < h_half));
        hs_act = run && (h_pos < HW'(HS_PIX));
        vs_act = run && (field_even ? vs_even_win : vs_odd_win);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
        end else begin
            hsync_n <= ~hs_act;
            vsync_n <= ~vs_act;
        end
    end

    // R8
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (hsync_n && vsync_n));

    // R3
    hs_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |-> ($past(h_pos) == '0));
endmodule

// File: rtl/ilace_sync_gen.sv
module ilace_sync_gen #(
    parameter int H_NTSC      = 858,
    parameter int H_PAL       = 864,
    parameter int V_NTSC      = 525,
    parameter int V_PAL       = 625,
    parameter int HS_PIX      = 32,
    parameter int VS_LINES    = 2,
    parameter int VS_ODD_NTSC = 4,
    parameter int VS_ODD_PAL  = 1,
    localparam int HW = $clog2(((H_PAL > H_NTSC) ? H_PAL : H_NTSC) + 1),
    localparam int LW = $clog2(((V_PAL > V_NTSC) ? V_PAL : V_NTSC) + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    output logic          pix_en,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic [HW-1:0] h_pos,
    output logic [LW-1:0] line_num,
    output logic          field_even
);
    import isg_pkg::*;

    localparam int F2_NTSC = (V_NTSC + 1) / 2;
    localparam int F2_PAL  = (V_PAL + 1) / 2;
    localparam int VE_NTSC = F2_NTSC + VS_ODD_NTSC - 1;
    localparam int VE_PAL  = F2_PAL + VS_ODD_PAL - 1;

    vmode_e        cur_mode;
    logic          run, adv, line_end, frame_end;
    logic [HW-1:0] h_max, h_half;
    logic [LW-1:0] v_max, f2_line, vo_line, ve_line;

    // Raster geometry of the mode latched at the last frame wrap.
    always_comb begin
        if (cur_mode == MODE_PAL) begin
            h_max   = HW'(H_PAL);
            h_half  = HW'(H_PAL / 2);
            v_max   = LW'(V_PAL);
            f2_line = LW'(F2_PAL);
            vo_line = LW'(VS_ODD_PAL);
            ve_line = LW'(VE_PAL);
        end else begin
            h_max   = HW'(H_NTSC);
            h_half  = HW'(H_NTSC / 2);
            v_max   = LW'(V_NTSC);
            f2_line = LW'(F2_NTSC);
            vo_line = LW'(VS_ODD_NTSC);
            ve_line = LW'(VE_NTSC);
        end
        adv = pix_en && run;
    end

    isg_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .pix_en (pix_en)
    );

    isg_counters #(.HW(HW), .LW(LW)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .h_max     (h_max),
        .v_max     (v_max),
        .h_pos     (h_pos),
        .line_num  (line_num),
        .line_end  (line_end),
        .frame_end (frame_end)
    );

    isg_field_fsm #(.LW(LW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_in    (vmode_e'(mode)),
        .tick       (pix_en),
        .line_end   (line_end),
        .frame_end  (frame_end),
        .line_num   (line_num),
        .f2_line    (f2_line),
        .cur_mode   (cur_mode),
        .run        (run),
        .field_even (field_even)
    );

    isg_sync_decode #(.HW(HW), .LW(LW), .HS_PIX(HS_PIX), .VS_LINES(VS_LINES)) u_dec (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .field_even   (field_even),
        .h_pos        (h_pos),
        .line_num     (line_num),
        .h_half       (h_half),
        .vs_odd_line  (vo_line),
        .vs_even_line (ve_line),
        .hsync_n      (hsync_n),
        .vsync_n      (vsync_n)
    );
endmodule

// File: tb/test_ilace_sync_gen.sv
module test_ilace_sync_gen;
    localparam int CLK_PERIOD = 10;
    localparam int BH_N = 80;
    localparam int BH_P = 84;
    localparam int BV_N = 11;
    localparam int BV_P = 13;
    localparam int HSP  = 32;
    localparam int VO_N = 4;
    localparam int VO_P = 1;
    localparam int HWB  = $clog2(BH_P + 1);
    localparam int LWB  = $clog2(BV_P + 1);

    // Vector table: mode code, expected pixels per line, lines, second-field line, odd vsync line
    localparam int NV = 4;
    localparam logic [1:0] T_MODE [NV] = '{2'b11, 2'b10, 2'b01, 2'b10};
    localparam int T_H  [NV] = '{BH_N, BH_P, BH_N, BH_P};
    localparam int T_V  [NV] = '{BV_N, BV_P, BV_N, BV_P};
    localparam int T_F2 [NV] = '{(BV_N+1)/2, (BV_P+1)/2, (BV_N+1)/2, (BV_P+1)/2};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'b11;
    logic pix_en, hsync_n, vsync_n, field_even;
    logic [HWB-1:0] h_pos;
    logic [LWB-1:0] line_num;

    int n_tests = 0;
    int n_fail  = 0;

    int r_hs_falls, r_hs_bad, r_first_fall, r_period, r_last_hs_fall;
    int r_max_line, r_max_h, r_even_line, r_vs_n, r_vs_fall_t;
    int r_vs_len [2];
    int r_vs_off [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    ilace_sync_gen #(
        .H_NTSC(BH_N), .H_PAL(BH_P), .V_NTSC(BV_N), .V_PAL(BV_P),
        .HS_PIX(HSP), .VS_LINES(2), .VS_ODD_NTSC(VO_N), .VS_ODD_PAL(VO_P)
    ) i_ilace_sync_gen (
        .clk(clk), .rst(rst), .mode(mode), .pix_en(pix_en),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .h_pos(h_pos),
        .line_num(line_num), .field_even(field_even)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic wait_frame_start();
        while (line_num == 1) @(negedge clk);
        while (line_num != 1) @(negedge clk);
    endtask

    // Scans one frame starting at line 1, pixel 0.
    task automatic run_frame();
        int t = 0;
        logic phs = hsync_n;
        logic pvs = vsync_n;
        int pline;
        r_hs_falls = 0; r_hs_bad = 0; r_first_fall = -1; r_period = -1;
        r_last_hs_fall = 0; r_max_line = 0; r_max_h = 0; r_even_line = -1;
        r_vs_n = 0; r_vs_fall_t = 0;
        r_vs_len = '{-1, -1}; r_vs_off = '{-1, -1};
        while (1) begin
            if (int'(line_num) > r_max_line) r_max_line = int'(line_num);
            if (int'(h_pos) > r_max_h) r_max_h = int'(h_pos);
            if (field_even && r_even_line < 0) r_even_line = int'(line_num);
            if (phs && !hsync_n) begin
                r_hs_falls++;
                if (r_first_fall < 0) r_first_fall = t;
                else if (r_period < 0) r_period = t - r_first_fall;
                r_last_hs_fall = t;
            end
            if (!phs && hsync_n && (t - r_last_hs_fall) != 2*HSP) r_hs_bad++;
            if (pvs && !vsync_n) begin
                if (r_vs_n < 2) r_vs_off[r_vs_n] = t - r_last_hs_fall;
                r_vs_fall_t = t;
                r_vs_n++;
            end
            if (!pvs && vsync_n && r_vs_n >= 1 && r_vs_n <= 2)
                r_vs_len[r_vs_n-1] = t - r_vs_fall_t;
            phs = hsync_n; pvs = vsync_n; pline = int'(line_num);
            @(negedge clk);
            t++;
            if (line_num == 1 && pline != 1) break;
            if (t > 6000) break;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 line_num in reset", int'(line_num), 1);
        chk("R10 h_pos in reset", int'(h_pos), 0);
        chk("R10 field_even in reset", int'(field_even), 0);
        chk("R10 hsync_n in reset", int'(hsync_n), 1);
        chk("R10 vsync_n in reset", int'(vsync_n), 1);
        chk("R10 pix_en in reset", int'(pix_en), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 hsync_n low right after reset", int'(hsync_n), 0);

        // Table walk: each mode measured over one full frame
        for (int i = 0; i < NV; i++) begin
            mode = T_MODE[i];
            wait_frame_start();
            run_frame();
            chk("R3 hsync low width 2*HS_PIX", r_hs_bad, 0);
            chk("R3 hsync pulses per frame", r_hs_falls, T_V[i]);
            chk("R1 line period in clocks", r_period, 2*T_H[i]);
            chk("R1 last pixel index", r_max_h, T_H[i]-1);
            chk("R2 lines per frame", r_max_line, T_V[i]);
            chk("R4 vsync pulses per frame", r_vs_n, 2);
            chk("R4 odd vsync width", r_vs_len[0], 4*T_H[i]);
            chk("R4 even vsync width", r_vs_len[1], 4*T_H[i]);
            chk("R5 odd vsync to hsync offset", r_vs_off[0], 0);
            chk("R5 even vsync to hsync offset", r_vs_off[1], T_H[i]);
            chk("R6 first even-field line", r_even_line, T_F2[i]);
        end

        // R9: mid-frame mode change waits for the frame wrap (current mode 10)
        while (line_num != 3) @(negedge clk);
        mode = 2'b11;
        begin
            int mh = 0;
            int ml = 0;
            while (line_num != 1) begin
                if (int'(h_pos) > mh) mh = int'(h_pos);
                if (int'(line_num) > ml) ml = int'(line_num);
                @(negedge clk);
            end
            chk("R9 old line length kept", mh, BH_P-1);
            chk("R9 old line count kept", ml, BV_P);
        end
        run_frame();
        chk("R9 new line length after wrap", r_max_h, BH_N-1);
        chk("R9 new line count after wrap", r_max_line, BV_N);

        // R8: sleep parks at frame wrap, clocks keep running
        while (line_num != 3) @(negedge clk);
        mode = 2'b00;
        wait_frame_start();
        begin
            int bad = 0;
            int hi = 0;
            int same = 0;
            logic pp = pix_en;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (!hsync_n || !vsync_n || line_num != 1 || h_pos != 0 || field_even) bad++;
                if (pix_en) hi++;
                if (pix_en == pp) same++;
                pp = pix_en;
            end
            chk("R8 sleep outputs parked", bad, 0);
            chk("R7 pix_en high count in sleep", hi, 100);
            chk("R7 pix_en alternates in sleep", same, 0);
        end
        mode = 2'b11;
        begin
            int seen = 0;
            for (int k = 0; k < 3 && !seen; k++) begin
                @(negedge clk);
                if (!hsync_n) seen = 1;
            end
            chk("R8 hsync resumes after wake", seen, 1);
            chk("R8 odd field after wake", int'(field_even), 0);
            chk("R8 line 1 after wake", int'(line_num), 1);
        end
        begin
            int changes = 0;
            logic [HWB-1:0] ph = h_pos;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (h_pos != ph) changes++;
                ph = h_pos;
            end
            chk("R7 h_pos advances every second clock", changes, 20);
        end

        // R10: reset in mid-frame, new mode adopted from reset
        while (line_num != 7) @(negedge clk);
        rst = 1'b1;
        mode = 2'b10;
        @(negedge clk);
        @(negedge clk);
        chk("R10 line_num after mid-run reset", int'(line_num), 1);
        chk("R10 h_pos after mid-run reset", int'(h_pos), 0);
        chk("R10 field_even after mid-run reset", int'(field_even), 0);
        chk("R10 hsync_n after mid-run reset", int'(hsync_n), 1);
        rst = 1'b0;
        @(negedge clk);
        run_frame();
        chk("R10 mode sampled at reset sets line count", r_max_line, BV_P);

        finish_run();
    end
endmodule